// File: doc/BRIEF.md
# Synthesizer Loop Core: Dividers, Phase Comparator and Lock Flag

This block is the digital heart of a frequency synthesizer. It divides a crystal-derived tick stream by a fixed 512 to form the comparison reference. It divides the prescaled RF tick stream by a 15-bit ratio held in a bus-written latch. A phase/frequency comparator then turns the timing difference between the two divided edges into up and down pump requests. A lock detector watches those requests and raises a flag once the loop has settled. With a 4 MHz crystal the comparison rate is 7.8125 kHz. Because the RF input passes through an external divide-by-8 prescaler, each ratio step is 62.5 kHz of RF.

The core runs on one fast system clock. The crystal clock and the prescaled RF clock arrive as single-cycle enable strobes (`xtal_tick`, `rf_tick`), one per edge of the clock they stand for. Pulse widths and the lock window are therefore measured in system clock cycles. Two control bits support bring-up and test. One routes the divided RF and reference clocks onto two general-purpose port pins. The other forces the pump into its high-impedance state. A third control bit selects the low or high pump current. There is no streaming data path: every pin is a plain control or status level.

Top module: `pll_loop_core`

## Requirements
- R1: The reference divider produces one comparison edge per 512 `xtal_tick` strobes. Its divided clock is high for the first 256 ticks of each period and rises on the tick that follows a comparison edge.
- R2: The programmable divider produces one divider edge per N `rf_tick` strobes, where N is the unsigned value of `ratio`. N values 0 and 1 behave as 2. Its divided clock is high while the count is below N/2.
- R3: A new `ratio` value is taken up only when the running count reaches its terminal value. The period in progress keeps the old ratio. On reset the ratio present at that time is loaded directly.
- R4: A comparison edge raises the up request in the next cycle, and a divider edge raises the down request in the next cycle. When the second edge arrives, both requests clear, so up and down are never high together. Edges in the same cycle assert neither. A lag of k cycles therefore gives an up (or down) pulse exactly k cycles wide.
- R5: While `t0` is 1, `pump_up` and `pump_dn` are 0 and `pump_hiz` is 1, whatever the phase error. While `t0` is 0, `pump_hiz` is 0.
- R6: `cur_hi` follows `cp`: 0 selects the low (about 50 µA) current and 1 the high (about 220 µA) current.
- R7: With `t1` = 1, `p2_out` carries the divided RF clock and `p6_out` the divided reference clock. With `t1` = 0 they pass `port_p2` and `port_p6` through.
- R8: `locked` rises only on a comparison edge. It does so at the 4th consecutive comparison edge whose preceding period held no request pulse longer than 8 system cycles.
- R9: In the cycle after a request pulse has stayed high for a 9th cycle, `locked` is 0. The run of good periods restarts from zero.
- R10: After reset, `pump_up`, `pump_dn` and `locked` are 0, and both dividers restart from count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_tick | input | 1 | One-cycle strobe per crystal clock edge |
| rf_tick | input | 1 | One-cycle strobe per prescaled RF clock edge |
| ratio | input | 15 | Programmable divide ratio from the bus latch |
| cp | input | 1 | Pump current select |
| t0 | input | 1 | Force pump to high impedance |
| t1 | input | 1 | Route divided clocks to the port pins |
| port_p2 | input | 1 | Normal value for port P2 |
| port_p6 | input | 1 | Normal value for port P6 |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| pump_hiz | output | 1 | Pump output high impedance |
| cur_hi | output | 1 | High pump current selected |
| p2_out | output | 1 | Port P2 drive (divided RF clock in test mode) |
| p6_out | output | 1 | Port P6 drive (divided reference clock in test mode) |
| locked | output | 1 | Loop-in-lock flag |

## Verification
The hardest state to reach from the ports is a lock that is lost part-way through a request pulse. The bench first lets both dividers run aligned until the flag is set. It then withholds RF strobes for a chosen number of cycles, so that the divider lags by exactly that amount. It then watches the next up pulse cycle by cycle and samples the flag before and after the window boundary while the pulse is still high. The same withholding, applied to one stream or the other, sets precise pulse widths for the up, down and tri-state checks. A ratio change in the middle of a count is timed against rises of the routed test clock.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
  localparam int unsigned REF_DIV_DEF  = 512;
  localparam int unsigned RATIO_W_DEF  = 15;
  localparam int unsigned LOCK_WIN_DEF = 8;
  localparam int unsigned LOCK_RUN_DEF = 4;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int unsigned REF_DIV = pll_core_pkg::REF_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic ref_edge,
  output logic ref_clk
);
  localparam int unsigned CW = $clog2(REF_DIV);

  logic [CW-1:0] cnt_q;

  assign ref_edge = tick && (cnt_q == CW'(REF_DIV - 1));
  assign ref_clk  = (cnt_q < CW'(REF_DIV / 2));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (ref_edge) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + CW'(1);
  end

  // R1
  ref_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> !ref_edge);
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int unsigned W = pll_core_pkg::RATIO_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         div_edge,
  output logic         div_clk
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic [W-1:0] ratio_eff;

  assign ratio_eff = (ratio < W'(2)) ? W'(2) : ratio;
  assign div_edge  = tick && (cnt_q == act_q - W'(1));
  assign div_clk   = (cnt_q < (act_q >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= ratio_eff;
    end else if (div_edge) begin
      cnt_q <= '0;
      act_q <= ratio_eff;
    end else if (tick) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !div_edge |=> $stable(act_q));
  // R2
  div_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    div_edge |=> !div_edge);
endmodule

// File: rtl/phase_comp.sv
module phase_comp (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_edge,
  input  logic                   div_edge,
  output pll_core_pkg::pump_req_t req
);
  logic up_set, dn_set;

  assign up_set = req.up | ref_edge;
  assign dn_set = req.dn | div_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= '0;
    end else if (up_set && dn_set) begin
      req <= '0;
    end else begin
      req.up <= up_set;
      req.dn <= dn_set;
    end
  end

  // R4
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(req.up && req.dn));
  // R4
  up_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req.up) |-> $past(ref_edge));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int unsigned WIN = pll_core_pkg::LOCK_WIN_DEF,
  parameter int unsigned RUN = pll_core_pkg::LOCK_RUN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int unsigned WW = $clog2(WIN + 1);
  localparam int unsigned GW = $clog2(RUN + 1);

  logic [WW-1:0] width_q;
  logic [GW-1:0] good_q;
  logic          bad_q;
  logic          active, wide;

  assign active = up | dn;
  assign wide   = active && (width_q == WW'(WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      good_q  <= '0;
      bad_q   <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (!active)       width_q <= '0;
      else if (!wide)    width_q <= width_q + WW'(1);

      if (ref_edge) begin
        bad_q <= 1'b0;
        if (bad_q || wide) begin
          good_q <= '0;
          locked <= 1'b0;
        end else begin
          if (good_q != GW'(RUN)) good_q <= good_q + GW'(1);
          locked <= (good_q >= GW'(RUN - 1));
        end
      end else if (wide) begin
        bad_q  <= 1'b1;
        good_q <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R9
  wide_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    wide |=> !locked);
  // R8
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_edge));
endmodule

// File: rtl/pll_loop_core.sv
module pll_loop_core #(
  parameter int unsigned REF_DIV  = pll_core_pkg::REF_DIV_DEF,
  parameter int unsigned RATIO_W  = pll_core_pkg::RATIO_W_DEF,
  parameter int unsigned LOCK_WIN = pll_core_pkg::LOCK_WIN_DEF,
  parameter int unsigned LOCK_RUN = pll_core_pkg::LOCK_RUN_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xtal_tick,
  input  logic               rf_tick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               cp,
  input  logic               t0,
  input  logic               t1,
  input  logic               port_p2,
  input  logic               port_p6,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               pump_hiz,
  output logic               cur_hi,
  output logic               p2_out,
  output logic               p6_out,
  output logic               locked
);
  logic ref_edge, ref_clk, div_edge, div_clk;
  pll_core_pkg::pump_req_t req;

  ref_divider #(.REF_DIV(REF_DIV)) u_ref (
    .clk(clk), .rst(rst), .tick(xtal_tick),
    .ref_edge(ref_edge), .ref_clk(ref_clk)
  );

  prog_divider #(.W(RATIO_W)) u_div (
    .clk(clk), .rst(rst), .tick(rf_tick), .ratio(ratio),
    .div_edge(div_edge), .div_clk(div_clk)
  );

  phase_comp u_pfd (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .div_edge(div_edge), .req(req)
  );

  lock_detect #(.WIN(LOCK_WIN), .RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst(rst), .ref_edge(ref_edge),
    .up(req.up), .dn(req.dn), .locked(locked)
  );

  assign pump_hiz = t0;
  assign pump_up  = req.up & ~t0;
  assign pump_dn  = req.dn & ~t0;
  assign cur_hi   = cp;
  assign p2_out   = t1 ? div_clk : port_p2;
  assign p6_out   = t1 ? ref_clk : port_p6;

  // R5
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pump_hiz |-> !(pump_up || pump_dn));
  // R4
  dn_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req.dn) |-> $past(div_edge));
endmodule

// File: tb/tb_pll_loop_core.sv
`timescale 1ns/1ps
module tb_pll_loop_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xt_en = 1'b1, rf_en = 1'b1, xt_half = 1'b0;
  logic [14:0] ratio = 15'd512;
  logic cp = 1'b0, t0 = 1'b0, t1 = 1'b0, port_p2 = 1'b0, port_p6 = 1'b0;
  logic pump_up, pump_dn, pump_hiz, cur_hi, p2_out, p6_out, locked;

  int checks = 0, failures = 0;
  int up_run = 0, up_max = 0, dn_run = 0, dn_max = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_loop_core dut (
    .clk(clk), .rst(rst), .xtal_tick(xt_en), .rf_tick(rf_en), .ratio(ratio),
    .cp(cp), .t0(t0), .t1(t1), .port_p2(port_p2), .port_p6(port_p6),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_hi(cur_hi),
    .p2_out(p2_out), .p6_out(p6_out), .locked(locked)
  );

  always @(negedge clk) begin
    if (xt_half) xt_en <= ~xt_en;
    up_run = pump_up ? up_run + 1 : 0;
    dn_run = pump_dn ? dn_run + 1 : 0;
    if (up_run > up_max) up_max = up_run;
    if (dn_run > dn_max) dn_max = dn_run;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    @(posedge clk);
    up_max = 0; dn_max = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; xt_en = 1'b1; rf_en = 1'b1; xt_half = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic find_rise(input bit sel, output int n);
    bit prev, cur;
    prev = sel ? p6_out : p2_out;
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      cur = sel ? p6_out : p2_out;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic drop_rf(input int k);
    @(negedge clk); rf_en = 1'b0; cyc(k); rf_en = 1'b1;
  endtask

  task automatic drop_xt(input int k);
    @(negedge clk); xt_en = 1'b0; cyc(k); xt_en = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(1);
    chk("R10 pump_up", pump_up, 0);
    chk("R10 pump_dn", pump_dn, 0);
    chk("R10 locked", locked, 0);
    chk("R5 hiz off", pump_hiz, 0);
  endtask

  task automatic t_cp();
    cp = 1'b1; cyc(1); chk("R6 cp=1", cur_hi, 1);
    cp = 1'b0; cyc(1); chk("R6 cp=0", cur_hi, 0);
  endtask

  task automatic t_acquire();
    ratio = 15'd512;
    do_reset();
    clr_mon();
    cyc(1800); chk("R8 no lock at 3 edges", locked, 0);
    cyc(500);  chk("R8 lock after 4 edges", locked, 1);
    chk("R4 coincident no up", up_max, 0);
    chk("R4 coincident no dn", dn_max, 0);
  endtask

  task automatic t_lag();
    drop_rf(3);
    clr_mon();
    cyc(1100);
    chk("R4 up width", up_max, 3);
    chk("R4 no dn on lag", dn_max, 0);
    chk("R8 lock kept in window", locked, 1);
  endtask

  task automatic t_lead();
    do_reset(); cyc(2300);
    drop_xt(5);
    clr_mon();
    cyc(1100);
    chk("R4 dn width", dn_max, 5);
    chk("R4 no up on lead", up_max, 0);
  endtask

  task automatic t_unlock();
    int guard = 0;
    do_reset(); cyc(2300);
    chk("R9 pre locked", locked, 1);
    drop_rf(20);
    while (!pump_up && guard < 2000) begin @(negedge clk); guard++; end
    cyc(5);
    chk("R9 still locked inside window", locked, 1);
    cyc(10);
    chk("R9 pulse still high", pump_up, 1);
    chk("R9 unlocked mid pulse", locked, 0);
    cyc(2100);
    chk("R9 stays unlocked", locked, 0);
  endtask

  task automatic t_tristate();
    t0 = 1'b1;
    clr_mon(); cyc(1100);
    chk("R5 up held", up_max, 0);
    chk("R5 dn held", dn_max, 0);
    chk("R5 hiz", pump_hiz, 1);
    @(negedge clk); t0 = 1'b0;
    clr_mon(); cyc(1100);
    chk("R5 released up width", up_max, 20);
  endtask

  task automatic t_route();
    int n;
    do_reset();
    t1 = 1'b0; port_p2 = 1'b1; port_p6 = 1'b0; cyc(1);
    chk("R7 p2 pass", p2_out, 1); chk("R7 p6 pass", p6_out, 0);
    port_p2 = 1'b0; port_p6 = 1'b1; cyc(1);
    chk("R7 p2 pass 0", p2_out, 0); chk("R7 p6 pass 1", p6_out, 1);
    t1 = 1'b1;
    find_rise(1'b1, n); find_rise(1'b1, n);
    chk("R1 ref period", n, 512);
    @(negedge clk); xt_half = 1'b1;
    find_rise(1'b1, n); find_rise(1'b1, n);
    chk("R1 ref period half rate", n, 1024);
    @(negedge clk); xt_half = 1'b0; xt_en = 1'b1;
  endtask

  task automatic t_ratio();
    int n;
    ratio = 15'd512; t1 = 1'b1;
    do_reset();
    find_rise(1'b0, n);
    cyc(50); ratio = 15'd100;
    find_rise(1'b0, n); chk("R3 old ratio finishes", n + 50, 512);
    find_rise(1'b0, n); chk("R3 new ratio", n, 100);
    find_rise(1'b0, n); chk("R2 period 100", n, 100);
    ratio = 15'd37;
    find_rise(1'b0, n); find_rise(1'b0, n); chk("R2 odd ratio", n, 37);
    ratio = 15'd0;
    do_reset();
    find_rise(1'b0, n); find_rise(1'b0, n); chk("R2 ratio 0", n, 2);
    ratio = 15'd1;
    find_rise(1'b0, n); find_rise(1'b0, n); chk("R2 ratio 1", n, 2);
    t1 = 1'b0; ratio = 15'd512;
  endtask

  initial begin
    t_reset();
    t_cp();
    t_acquire();
    t_lag();
    t_lead();
    t_unlock();
    t_tristate();
    t_route();
    t_ratio();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule